// File: doc/BRIEF.md
# Serial Controller Status and Error-Flag Register

This block keeps the status word of a serial peripheral controller: an operating-enable level that separates configuration from active mode, a master-select level, and six sticky error flags (mode fault, transmit overflow, receive overflow, abort, transmit underflow and receive underflow). Software never writes the status word itself. Instead it writes a separate command word in which every status bit has its own set bit and its own clear bit, so one flag can change without a read-modify-write of the others.

Error event pulses from the shift engine raise the flags, and five of them are gated by detection-enable inputs taken from the controller's control word. A raised flag holds until software clears it. While any flag is up and the error interrupt is enabled, a single error interrupt request is driven. The status word also carries a busy level passed through from the shift engine, so a bus read port can expose the whole word.

Top module: `spi_status_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every stored status bit is cleared, and after that edge `status_word` shows zero apart from the busy bit, with `enable_o`, `master_o` and `err_irq` low.
- R2: A command write (`cmd_we` high) with bit 1 set raises the enable bit; bit 0 lowers it. The new value shows on `status_word[0]` and `enable_o` from the clock edge that takes the write.
- R3: Command bit 3 raises the master-select bit and command bit 2 lowers it; the value shows on `status_word[1]` and `master_o` from the edge that takes the write.
- R4: `status_word` places the flags at mode fault 7, transmit overflow 8, receive overflow 9, abort 10, transmit underflow 11, receive underflow 12, with `busy_in` copied to bit 13 in the same cycle; bits 2 to 6, 14 and 15 read zero.
- R5: Command bits set and clear the error flags by these pairs (clear, set): receive underflow 4/5, mode fault 6/7, transmit overflow 8/12, receive overflow 9/13, abort 10/14, transmit underflow 11/15.
- R6: `err_event` bits 0 to 5 report mode fault, transmit overflow, receive overflow, abort, transmit underflow, receive underflow. A pulse raises its flag at the next edge; the mode-fault event always counts, and the other five count only when `det_en` bits 0 to 4 (in the same order) are high.
- R7: A raised flag stays set until a command write with its clear bit; cycles with `cmd_we` low, whatever `cmd_word` holds, and writes with the clear bit low leave every status bit as it was.
- R8: When one write both sets and clears the same bit, the bit ends cleared.
- R9: An error event that counts and a software clear of the same flag in one cycle leave the flag set.
- R10: `err_irq` is high exactly while `irq_err_en` is high and at least one of the six error flags is set, following the flags and `irq_err_en` in the same cycle.
- R11: Error events never change the enable or master-select bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Set/clear command word |
| err_event | input | 6 | Error event pulses from the shift engine |
| det_en | input | 5 | Detection enables for the five gated errors |
| busy_in | input | 1 | Busy level from the shift engine |
| irq_err_en | input | 1 | Error interrupt enable |
| status_word | output | 16 | Assembled status word |
| enable_o | output | 1 | Operating-enable level |
| master_o | output | 1 | Master-select level |
| err_irq | output | 1 | Error interrupt request |

## Verification
Every stored bit reaches the ports through `status_word` one edge after the write or event that changes it, so a wrong priority, a swapped command bit or a missing gate shows up at the very next sample as a mismatched bit in a known position. A flag that fails to hold shows once the stimulus stops, and a flag that fails to clear also drags `err_irq` along, so the interrupt check catches the same fault from a second angle. The priority corners (set against clear, event against clear) are driven in single cycles so their outcome cannot be hidden by a later write.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int CMD_W     = 16;
    localparam int STAT_W    = 16;
    localparam int NUM_ERR   = 6;
    localparam int NUM_GATED = NUM_ERR - 1;

    // Status word positions of the non-error bits.
    localparam int POS_EN    = 0;
    localparam int POS_MS    = 1;
    localparam int POS_BUSY  = 13;
    localparam int POS_ERR0  = 7;

    // Command word positions of the mode bits.
    localparam int CMD_EN_CLR = 0;
    localparam int CMD_EN_SET = 1;
    localparam int CMD_MS_CLR = 2;
    localparam int CMD_MS_SET = 3;

    // Error flag index; index 0 is never gated by a detection enable.
    typedef enum logic [2:0] {
        ERR_MODE  = 3'd0,
        ERR_TXOVF = 3'd1,
        ERR_RXOVF = 3'd2,
        ERR_ABORT = 3'd3,
        ERR_TXUND = 3'd4,
        ERR_RXUND = 3'd5
    } err_idx_e;

    typedef struct packed {
        logic [NUM_ERR-1:0] err_set;
        logic [NUM_ERR-1:0] err_clr;
        logic               en_set;
        logic               en_clr;
        logic               ms_set;
        logic               ms_clr;
    } cmd_fields_t;

    function automatic int err_stat_pos(input int idx);
        return POS_ERR0 + idx;
    endfunction

    function automatic int err_clr_pos(input int idx);
        case (idx)
            ERR_MODE:  return 6;
            ERR_TXOVF: return 8;
            ERR_RXOVF: return 9;
            ERR_ABORT: return 10;
            ERR_TXUND: return 11;
            default:   return 4;
        endcase
    endfunction

    function automatic int err_set_pos(input int idx);
        case (idx)
            ERR_MODE:  return 7;
            ERR_TXOVF: return 12;
            ERR_RXOVF: return 13;
            ERR_ABORT: return 14;
            ERR_TXUND: return 15;
            default:   return 5;
        endcase
    endfunction

endpackage

// File: rtl/stat_cmd_decode.sv
module stat_cmd_decode
    import spi_stat_pkg::*;
(
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    output cmd_fields_t      fields
);
    always_comb begin
        fields        = '0;
        fields.en_clr = cmd_we & cmd_word[CMD_EN_CLR];
        fields.en_set = cmd_we & cmd_word[CMD_EN_SET];
        fields.ms_clr = cmd_we & cmd_word[CMD_MS_CLR];
        fields.ms_set = cmd_we & cmd_word[CMD_MS_SET];
        for (int i = 0; i < NUM_ERR; i++) begin
            fields.err_clr[i] = cmd_we & cmd_word[err_clr_pos(i)];
            fields.err_set[i] = cmd_we & cmd_word[err_set_pos(i)];
        end
    end
endmodule

// File: rtl/stat_err_gate.sv
module stat_err_gate
    import spi_stat_pkg::*;
(
    input  logic [NUM_ERR-1:0]   err_event,
    input  logic [NUM_GATED-1:0] det_en,
    output logic [NUM_ERR-1:0]   err_hit
);
    // The mode fault has no detection enable; every other event has one.
    assign err_hit[ERR_MODE] = err_event[ERR_MODE];

    for (genvar g = 1; g < NUM_ERR; g++) begin : g_gate
        assign err_hit[g] = err_event[g] & det_en[g-1];
    end
endmodule

// File: rtl/stat_sticky_bit.sv
module stat_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic hw_raise,
    input  logic sw_clr,
    input  logic sw_set,
    output logic q
);
    // Priority: hardware raise, then software clear, then software set.
    always_ff @(posedge clk) begin
        if (rst)           q <= 1'b0;
        else if (hw_raise) q <= 1'b1;
        else if (sw_clr)   q <= 1'b0;
        else if (sw_set)   q <= 1'b1;
    end
endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit
    import spi_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_we,
    input  logic [CMD_W-1:0]     cmd_word,
    input  logic [NUM_ERR-1:0]   err_event,
    input  logic [NUM_GATED-1:0] det_en,
    input  logic                 busy_in,
    input  logic                 irq_err_en,
    output logic [STAT_W-1:0]    status_word,
    output logic                 enable_o,
    output logic                 master_o,
    output logic                 err_irq
);
    cmd_fields_t        cmd_f;
    logic [NUM_ERR-1:0] err_hit;
    logic [NUM_ERR-1:0] err_flag;

    stat_cmd_decode i_decode (
        .cmd_we   (cmd_we),
        .cmd_word (cmd_word),
        .fields   (cmd_f)
    );

    stat_err_gate i_gate (
        .err_event (err_event),
        .det_en    (det_en),
        .err_hit   (err_hit)
    );

    stat_sticky_bit i_en_bit (
        .clk      (clk),
        .rst      (rst),
        .hw_raise (1'b0),
        .sw_clr   (cmd_f.en_clr),
        .sw_set   (cmd_f.en_set),
        .q        (enable_o)
    );

    stat_sticky_bit i_ms_bit (
        .clk      (clk),
        .rst      (rst),
        .hw_raise (1'b0),
        .sw_clr   (cmd_f.ms_clr),
        .sw_set   (cmd_f.ms_set),
        .q        (master_o)
    );

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
        stat_sticky_bit i_flag (
            .clk      (clk),
            .rst      (rst),
            .hw_raise (err_hit[g]),
            .sw_clr   (cmd_f.err_clr[g]),
            .sw_set   (cmd_f.err_set[g]),
            .q        (err_flag[g])
        );
    end

    always_comb begin
        status_word           = '0;
        status_word[POS_EN]   = enable_o;
        status_word[POS_MS]   = master_o;
        status_word[POS_BUSY] = busy_in;
        for (int i = 0; i < NUM_ERR; i++) begin
            status_word[err_stat_pos(i)] = err_flag[i];
        end
    end

    assign err_irq = irq_err_en & (|err_flag);
endmodule

// File: rtl/stat_reg_chk.sv
module stat_reg_chk
    import spi_stat_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_we,
    input logic [CMD_W-1:0]     cmd_word,
    input logic [NUM_ERR-1:0]   err_event,
    input logic [NUM_GATED-1:0] det_en,
    input logic                 busy_in,
    input logic                 irq_err_en,
    input logic [STAT_W-1:0]    status_word,
    input logic                 enable_o,
    input logic                 master_o,
    input logic                 err_irq
);
    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_word[1] && !cmd_word[0] |=> enable_o);

    // R8
    en_clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_word[0] |=> !enable_o);

    // R3
    ms_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_word[2] |=> !master_o);

    // R6
    txovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        err_event[1] && det_en[0] |=> status_word[8]);

    // R6
    txovf_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_we && !det_en[0] && !status_word[8] |=> !status_word[8]);

    // R7
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[7] && !(cmd_we && cmd_word[6]) |=> status_word[7]);

    // R9
    rxund_event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        err_event[5] && det_en[4] && cmd_we && cmd_word[4] |=> status_word[12]);

    // R11
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> $stable(enable_o) && $stable(master_o));

    // R10
    irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> irq_err_en && (status_word[12:7] != '0));

    // R4
    zero_field_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[6:2] == '0 && status_word[15:14] == '0);
endmodule

bind spi_status_unit stat_reg_chk i_stat_reg_chk (.*);

// File: tb/test_spi_status_unit.sv
module test_spi_status_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_we;
    logic [15:0] cmd_word;
    logic [5:0]  err_event;
    logic [4:0]  det_en;
    logic        busy_in;
    logic        irq_err_en;
    logic [15:0] status_word;
    logic        enable_o;
    logic        master_o;
    logic        err_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] st;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state built from the requirements.
    logic       m_en = 1'b0;
    logic       m_ms = 1'b0;
    logic [5:0] m_f  = '0;

    always #5 clk = ~clk;

    spi_status_unit i_spi_status_unit (
        .clk         (clk),
        .rst         (rst),
        .cmd_we      (cmd_we),
        .cmd_word    (cmd_word),
        .err_event   (err_event),
        .det_en      (det_en),
        .busy_in     (busy_in),
        .irq_err_en  (irq_err_en),
        .status_word (status_word),
        .enable_o    (enable_o),
        .master_o    (master_o),
        .err_irq     (err_irq)
    );

    task automatic step(input logic r, input logic we, input logic [15:0] cmd,
                        input logic [5:0] ev, input logic [4:0] den,
                        input logic busy, input logic ien, input string tag);
        logic [5:0] clrb, setb, hit;
        exp_t e;
        @(negedge clk);
        rst = r; cmd_we = we; cmd_word = cmd; err_event = ev;
        det_en = den; busy_in = busy; irq_err_en = ien;
        clrb = we ? {cmd[4], cmd[11], cmd[10], cmd[9], cmd[8], cmd[6]} : 6'b0;
        setb = we ? {cmd[5], cmd[15], cmd[14], cmd[13], cmd[12], cmd[7]} : 6'b0;
        hit  = ev & {den, 1'b1};
        if (r) begin
            m_en = 1'b0; m_ms = 1'b0; m_f = '0;
        end else begin
            if (we && cmd[0])      m_en = 1'b0;
            else if (we && cmd[1]) m_en = 1'b1;
            if (we && cmd[2])      m_ms = 1'b0;
            else if (we && cmd[3]) m_ms = 1'b1;
            for (int i = 0; i < 6; i++) begin
                if (hit[i])       m_f[i] = 1'b1;
                else if (clrb[i]) m_f[i] = 1'b0;
                else if (setb[i]) m_f[i] = 1'b1;
            end
        end
        e.st  = {2'b00, busy, m_f[5], m_f[4], m_f[3], m_f[2], m_f[1], m_f[0],
                 5'b00000, m_ms, m_en};
        e.irq = ien & (|m_f);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares after each edge that takes a driven step.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (status_word !== e.st || enable_o !== e.st[0] ||
                    master_o !== e.st[1] || err_irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: status=%h en=%b ms=%b irq=%b expected status=%h irq=%b",
                             e.tag, status_word, enable_o, master_o, err_irq, e.st, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_we = 1'b0; cmd_word = '0; err_event = '0;
        det_en = '0; busy_in = 1'b0; irq_err_en = 1'b0;
        // R1 reset state
        step(1, 0, 16'h0000, 6'h00, 5'h00, 0, 1, "R1");
        step(1, 0, 16'h0000, 6'h00, 5'h00, 0, 1, "R1");
        // R2 / R3 enable and master control
        step(0, 1, 16'h0002, 6'h00, 5'h00, 0, 1, "R2");
        step(0, 1, 16'h0008, 6'h00, 5'h00, 0, 1, "R3");
        step(0, 1, 16'h0003, 6'h00, 5'h00, 0, 1, "R8");
        step(0, 1, 16'h000E, 6'h00, 5'h00, 0, 1, "R8");
        step(0, 1, 16'h0002, 6'h00, 5'h00, 0, 1, "R2");
        step(0, 1, 16'h0004, 6'h00, 5'h00, 0, 1, "R3");
        step(0, 1, 16'h0008, 6'h00, 5'h00, 0, 1, "R3");
        // R6 gated events are dropped when detection is off
        step(0, 0, 16'h0000, 6'h3E, 5'h00, 0, 1, "R6");
        step(0, 0, 16'h0000, 6'h00, 5'h00, 0, 1, "R6");
        // R6 / R4 each event in turn with detection on
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 16'h0000, 6'(1 << i), 5'h1F, 0, 1, "R6");
        end
        // R11 events left the control levels alone
        step(0, 0, 16'h0000, 6'h3F, 5'h1F, 0, 1, "R11");
        // R7 ignored writes and writes without clear bits
        step(0, 0, 16'hFFFF, 6'h00, 5'h1F, 0, 1, "R7");
        step(0, 1, 16'h000A, 6'h00, 5'h1F, 0, 1, "R7");
        // R4 busy follows input
        step(0, 0, 16'h0000, 6'h00, 5'h1F, 1, 1, "R4");
        // R10 interrupt masked
        step(0, 0, 16'h0000, 6'h00, 5'h1F, 1, 0, "R10");
        // R5 clear each flag separately
        step(0, 1, 16'h0010, 6'h00, 5'h1F, 0, 1, "R5");
        step(0, 1, 16'h0040, 6'h00, 5'h1F, 0, 1, "R5");
        step(0, 1, 16'h0100, 6'h00, 5'h1F, 0, 1, "R5");
        step(0, 1, 16'h0200, 6'h00, 5'h1F, 0, 1, "R5");
        step(0, 1, 16'h0400, 6'h00, 5'h1F, 0, 1, "R5");
        step(0, 1, 16'h0800, 6'h00, 5'h1F, 0, 1, "R10");
        // R5 set each flag separately
        step(0, 1, 16'h0020, 6'h00, 5'h00, 0, 1, "R5");
        step(0, 1, 16'h0080, 6'h00, 5'h00, 0, 1, "R5");
        step(0, 1, 16'h1000, 6'h00, 5'h00, 0, 1, "R5");
        step(0, 1, 16'h2000, 6'h00, 5'h00, 0, 1, "R5");
        step(0, 1, 16'h4000, 6'h00, 5'h00, 0, 1, "R5");
        step(0, 1, 16'h8000, 6'h00, 5'h00, 0, 1, "R5");
        // R8 set and clear of all flags in one write
        step(0, 1, 16'hFFF0, 6'h00, 5'h00, 0, 1, "R8");
        // R9 event and clear together
        step(0, 1, 16'h0F50, 6'h3F, 5'h1F, 0, 1, "R9");
        step(0, 1, 16'h0F50, 6'h21, 5'h00, 0, 1, "R9");
        step(0, 1, 16'h0F50, 6'h00, 5'h00, 0, 1, "R10");
        // R1 reset from a busy state
        step(0, 1, 16'hF0AA, 6'h00, 5'h00, 0, 1, "R5");
        step(1, 0, 16'h0000, 6'h00, 5'h00, 0, 1, "R1");
        step(0, 0, 16'h0000, 6'h00, 5'h00, 0, 1, "R1");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule